// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block turns a remembered operation into the four condition flags, negative, zero, overflow and carry. An instruction pipeline saves only a class code, the result it produced and the second (source) operand. The flags are worked out later, when something actually reads them. The block rebuilds the missing first operand from the result and the source, then applies the carry and overflow rules that belong to the saved class. Byte and word compares are judged on their low 8 or 16 bits only.

Two further classes do the arithmetic themselves: an add that folds in the extend bit, and a subtract that folds in the extend bit. Each produces its result, a new extend bit and flags. In these two classes the zero flag can be cleared but never newly set, so a chain of such operations over a multi-word value reports zero only if every word was zero.

Every request is a one-cycle strobe. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `ccr_lazy_eval`

## Requirements
- R1: After reset, flags_q, x_q, result_q, err_q and done_q are all zero.
- R2: Flags are packed as flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C. Class 0 (raw) copies opa[3:0] to the flags. For every other known class, Z is set when the judged result is zero, and N is set only when the result's top bit is 1 and the result is not zero.
- R3: Class 2 (add) takes opa as the sum and opb as the addend. C is the carry out of (opa-opb)+opb. V is the signed overflow of that addition.
- R4: Class 3 (subtract) takes opa as the difference and opb as the subtrahend. C is the borrow of (opa+opb)-opb. V is the signed overflow of that subtraction.
- R5: Class 4 (byte compare) and class 5 (word compare) apply the R4 rules to the low 8 or 16 bits of opa and opb. All four flags come from that width only.
- R6: Class 6 (extended-add flags) treats opa as (opa-opb-1)+opb+1 and sets C to that sum's carry out. Class 7 (extended-subtract flags) treats opa as (opa+opb+1)-opb-1 and sets C to that borrow. V is the signed overflow in both classes.
- R7: Class 8 (shift) sets N and Z from opa and sets C when opb is nonzero, with V=0. Class 1 (logic) sets N and Z from opa, with V=0 and C=0.
- R8: Class 9 computes opa+opb+x_in and class 10 computes opa-opb-x_in. Each returns this value on result_q, sets the flags per R2 and R6, and sets x_q to the new carry or borrow.
- R9: For classes 9 and 10, Z is the newly computed zero ANDed with prev_flags[2].
- R10: A class code of 11 to 15 sets err_q for that request and leaves flags_q, x_q and result_q unchanged. For known classes err_q is 0.
- R11: Outputs change only on a clock edge where valid is high. done_q is high for exactly the cycle after each request.
- R12: For classes 0 to 8, result_q takes opa and x_q takes x_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Request strobe |
| op_class | input | 4 | Saved operation class code |
| opa | input | WIDTH | Saved result, or first operand for classes 9 and 10 |
| opb | input | WIDTH | Saved source operand |
| x_in | input | 1 | Current extend bit |
| prev_flags | input | 4 | Flags before this request, {N,Z,V,C} |
| flags_q | output | 4 | Evaluated flags {N,Z,V,C} |
| x_q | output | 1 | New extend bit |
| result_q | output | WIDTH | Arithmetic result or passed-through opa |
| err_q | output | 1 | Unknown class seen |
| done_q | output | 1 | Outputs were updated on the last edge |

## Verification
The sweep pairs every class with a set of edge operands: zero, one, all ones, and the values just either side of the sign boundary at 8, 16 and 32 bits. These expose a carry test that uses < where <= is needed (or the reverse), which misreports the case where the result equals the source. A compare that reads bits beyond its narrow width shows up as a wrong N or Z on byte compares of values such as 0x0100. A lost sticky-zero AND would report zero after a nonzero earlier word. Unknown codes are mixed between valid ones, so a design that overwrote the flags on an error would visibly lose the previous flags.

// File: rtl/ccr_lazy_eval.sv
module ccr_lazy_eval #(
  parameter int WIDTH = 32,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CW-1:0]    op_class,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             x_in,
  input  logic [3:0]       prev_flags,
  output logic [3:0]       flags_q,
  output logic             x_q,
  output logic [WIDTH-1:0] result_q,
  output logic             err_q,
  output logic             done_q
);

  localparam int MSB = WIDTH - 1;
  localparam logic [CW-1:0] C_RAW   = CW'(0);
  localparam logic [CW-1:0] C_LOGIC = CW'(1);
  localparam logic [CW-1:0] C_ADD   = CW'(2);
  localparam logic [CW-1:0] C_SUB   = CW'(3);
  localparam logic [CW-1:0] C_CMPB  = CW'(4);
  localparam logic [CW-1:0] C_CMPW  = CW'(5);
  localparam logic [CW-1:0] C_ADDXF = CW'(6);
  localparam logic [CW-1:0] C_SUBXF = CW'(7);
  localparam logic [CW-1:0] C_SHIFT = CW'(8);
  localparam logic [CW-1:0] C_ADDX  = CW'(9);
  localparam logic [CW-1:0] C_SUBX  = CW'(10);

  function automatic logic [3:0] nz_of(input logic [WIDTH-1:0] v);
    nz_of = {v[MSB] & (v != '0), v == '0, 2'b00};
  endfunction

  function automatic logic [3:0] add_rule(input logic [WIDTH-1:0] d,
                                          input logic [WIDTH-1:0] s,
                                          input logic one);
    logic [WIDTH-1:0] t;
    logic [3:0] f;
    t    = d - s - WIDTH'(one);
    f    = nz_of(d);
    f[1] = (s[MSB] ^ d[MSB]) & ~(t[MSB] ^ s[MSB]);
    f[0] = one ? (d <= s) : (d < s);
    return f;
  endfunction

  function automatic logic [3:0] sub_rule(input logic [WIDTH-1:0] d,
                                          input logic [WIDTH-1:0] s,
                                          input int w,
                                          input logic one);
    logic [WIDTH-1:0] m, dm, sm, t;
    logic [3:0] f;
    m    = (w >= WIDTH) ? '1 : ((WIDTH'(1) << w) - WIDTH'(1));
    dm   = d & m;
    sm   = s & m;
    t    = (dm + sm + WIDTH'(one)) & m;
    f[2] = (dm == '0);
    f[3] = dm[w-1] & ~f[2];
    f[1] = (t[w-1] ^ dm[w-1]) & (t[w-1] ^ sm[w-1]);
    f[0] = one ? (t <= sm) : (t < sm);
    return f;
  endfunction

  wire [WIDTH-1:0] sum_x  = opa + opb + WIDTH'(x_in);
  wire [WIDTH-1:0] diff_x = opa - opb - WIDTH'(x_in);

  logic [3:0]       nxt_flags;
  logic [3:0]       dp_f;
  logic             nxt_x;
  logic [WIDTH-1:0] nxt_res;
  logic             bad;

  always_comb begin
    nxt_flags = flags_q;
    nxt_x     = x_in;
    nxt_res   = opa;
    bad       = 1'b0;
    dp_f      = 4'b0;
    case (op_class)
      C_RAW:   nxt_flags = opa[3:0];
      C_LOGIC: nxt_flags = nz_of(opa);
      C_ADD:   nxt_flags = add_rule(opa, opb, 1'b0);
      C_SUB:   nxt_flags = sub_rule(opa, opb, WIDTH, 1'b0);
      C_CMPB:  nxt_flags = sub_rule(opa, opb, 8, 1'b0);
      C_CMPW:  nxt_flags = sub_rule(opa, opb, 16, 1'b0);
      C_ADDXF: nxt_flags = add_rule(opa, opb, 1'b1);
      C_SUBXF: nxt_flags = sub_rule(opa, opb, WIDTH, 1'b1);
      C_SHIFT: nxt_flags = nz_of(opa) | {3'b000, opb != '0};
      C_ADDX: begin
        dp_f      = add_rule(sum_x, opb, x_in);
        nxt_flags = {dp_f[3], dp_f[2] & prev_flags[2], dp_f[1:0]};
        nxt_x     = dp_f[0];
        nxt_res   = sum_x;
      end
      C_SUBX: begin
        dp_f      = sub_rule(diff_x, opb, WIDTH, x_in);
        nxt_flags = {dp_f[3], dp_f[2] & prev_flags[2], dp_f[1:0]};
        nxt_x     = dp_f[0];
        nxt_res   = diff_x;
      end
      default: begin
        bad     = 1'b1;
        nxt_x   = x_q;
        nxt_res = result_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= 4'b0;
      x_q      <= 1'b0;
      result_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= valid;
      if (valid) begin
        flags_q  <= nxt_flags;
        x_q      <= nxt_x;
        result_q <= nxt_res;
        err_q    <= bad;
      end
    end
  end

  // R2
  p_nz_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_class != C_RAW && op_class <= C_SUBX |=> !(flags_q[3] && flags_q[2]));

  p_logic_vc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_class == C_LOGIC |=> flags_q[1:0] == 2'b00);

  p_x_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op_class == C_ADDX || op_class == C_SUBX) |=> x_q == flags_q[0]);

  p_sticky_z_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op_class == C_ADDX || op_class == C_SUBX) && !prev_flags[2] |=> !flags_q[2]);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_class > C_SUBX |=> err_q && $stable(flags_q) && $stable(result_q) && $stable(x_q));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !done_q && $stable(flags_q) && $stable(result_q) && $stable(err_q));

  p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op_class <= C_SHIFT |=> result_q == $past(opa) && x_q == $past(x_in));

endmodule

// File: tb/sim_ccr_lazy_eval.sv
module sim_ccr_lazy_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op_class = 4'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        x_in = 1'b0;
  logic [3:0]  prev_flags = 4'd0;
  logic [3:0]  flags_q;
  logic        x_q;
  logic [31:0] result_q;
  logic        err_q, done_q;

  int checks = 0;
  int errors = 0;
  logic [3:0]  m_flags = 4'd0;
  logic        m_x = 1'b0;
  logic [31:0] m_res = '0;

  always #5 clk = ~clk;

  ccr_lazy_eval #(.WIDTH(32), .CW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op_class(op_class),
    .opa(opa), .opb(opb), .x_in(x_in), .prev_flags(prev_flags),
    .flags_q(flags_q), .x_q(x_q), .result_q(result_q),
    .err_q(err_q), .done_q(done_q));

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint sxw(input logic [31:0] v, input int w);
    longint r;
    r = longint'(v);
    if (v[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic logic ovf(input longint r, input int w);
    return (r > (longint'(1) << (w-1)) - 1) || (r < -(longint'(1) << (w-1)));
  endfunction

  function automatic logic [3:0] nzw(input logic [31:0] v, input int w);
    logic [31:0] m;
    m = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    if ((v & m) == 0) return 4'b0100;
    return {v[w-1], 3'b000};
  endfunction

  task automatic model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic xi, input logic [3:0] pf,
                       output logic [3:0] f, output logic xo, output logic [31:0] r,
                       output logic bad);
    logic [32:0] wide;
    logic [31:0] t, m, am, bm;
    int w;
    bad = 1'b0; xo = xi; r = a; f = 4'b0;
    case (c)
      4'd0: f = a[3:0];
      4'd1: f = nzw(a, 32);
      4'd2: begin
        t = a - b; wide = {1'b0, t} + {1'b0, b};
        f = nzw(a, 32) | {2'b00, ovf(sxw(t,32) + sxw(b,32), 32), wide[32]};
      end
      4'd3, 4'd4, 4'd5: begin
        w = (c == 4'd3) ? 32 : (c == 4'd4) ? 8 : 16;
        m = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
        am = a & m; bm = b & m; t = (am + bm) & m;
        f = nzw(a, w) | {2'b00, ovf(sxw(t,w) - sxw(bm,w), w), t < bm};
      end
      4'd6: begin
        t = a - b - 32'd1; wide = {1'b0, t} + {1'b0, b} + 33'd1;
        f = nzw(a, 32) | {2'b00, ovf(sxw(t,32) + sxw(b,32) + 1, 32), wide[32]};
      end
      4'd7: begin
        t = a + b + 32'd1;
        f = nzw(a, 32) | {2'b00, ovf(sxw(t,32) - sxw(b,32) - 1, 32),
                          {1'b0, t} < ({1'b0, b} + 33'd1)};
      end
      4'd8: f = nzw(a, 32) | {3'b000, b != 0};
      4'd9: begin
        wide = {1'b0, a} + {1'b0, b} + {32'd0, xi}; r = wide[31:0];
        f = nzw(r, 32) | {2'b00, ovf(sxw(a,32) + sxw(b,32) + longint'(xi), 32), wide[32]};
        f[2] = f[2] & pf[2]; xo = f[0];
      end
      4'd10: begin
        r = a - b - {31'd0, xi};
        f = nzw(r, 32) | {2'b00, ovf(sxw(a,32) - sxw(b,32) - longint'(xi), 32),
                          {1'b0, a} < ({1'b0, b} + {32'd0, xi})};
        f[2] = f[2] & pf[2]; xo = f[0];
      end
      default: begin bad = 1'b1; f = m_flags; xo = m_x; r = m_res; end
    endcase
  endtask

  function automatic string ftag(input logic [3:0] c);
    case (c)
      4'd0: return "R2 raw flags";
      4'd1: return "R7 logic flags";
      4'd2: return "R3 add flags";
      4'd3: return "R4 sub flags";
      4'd4, 4'd5: return "R5 narrow compare flags";
      4'd6, 4'd7: return "R6 extended flag eval";
      4'd8: return "R7 shift flags";
      4'd9, 4'd10: return "R8 extended datapath flags";
      default: return "R10 unknown class flags";
    endcase
  endfunction

  task automatic run(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                     input logic xi, input logic [3:0] pf);
    logic [3:0] f; logic xo; logic [31:0] r; logic bad;
    model(c, a, b, xi, pf, f, xo, r, bad);
    @(negedge clk);
    op_class = c; opa = a; opb = b; x_in = xi; prev_flags = pf; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    cmp(ftag(c), {60'd0, flags_q}, {60'd0, f});
    cmp(c >= 4'd9 && c <= 4'd10 ? "R8 result" : "R12 result", {32'd0, result_q}, {32'd0, r});
    cmp(c >= 4'd9 && c <= 4'd10 ? "R8 extend" : "R12 extend", {63'd0, x_q}, {63'd0, xo});
    cmp("R10 error flag", {63'd0, err_q}, {63'd0, bad});
    cmp("R11 done pulse", {63'd0, done_q}, 64'd1);
    if ((c == 4'd9 || c == 4'd10) && !pf[2])
      cmp("R9 sticky zero", {63'd0, flags_q[2]}, 64'd0);
    m_flags = f; m_x = xo; m_res = r;
  endtask

  logic [31:0] edge_v [14];
  initial begin
    edge_v[0] = 32'h0;        edge_v[1] = 32'h1;        edge_v[2] = 32'hffff_ffff;
    edge_v[3] = 32'h7fff_ffff; edge_v[4] = 32'h8000_0000; edge_v[5] = 32'h7f;
    edge_v[6] = 32'h80;       edge_v[7] = 32'hff;       edge_v[8] = 32'h7fff;
    edge_v[9] = 32'h8000;     edge_v[10] = 32'hffff;    edge_v[11] = 32'h100;
    edge_v[12] = 32'h1_0000;  edge_v[13] = 32'hffff_fffe;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    cmp("R1 reset flags", {60'd0, flags_q}, 64'd0);
    cmp("R1 reset result", {32'd0, result_q}, 64'd0);
    cmp("R1 reset x/err/done", {61'd0, x_q, err_q, done_q}, 64'd0);
    rst_n = 1'b1;

    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++)
          run(4'(c), edge_v[i], edge_v[j], 1'((i + j + c) & 1), 4'((i * 3 + j) & 15));

    lf = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(4'(k % 16), a, lf ^ (k[0] ? 32'h0 : a), 1'(k >> 1), 4'(k >> 2));
    end

    // R9 chained multi-word: nonzero word then zero word keeps Z clear
    run(4'd9, 32'h0, 32'h5, 1'b0, 4'b0100);
    run(4'd9, 32'h0, 32'h0, 1'b0, {m_flags[3], m_flags[2], m_flags[1:0]});
    cmp("R9 chained zero stays clear", {63'd0, flags_q[2]}, 64'd0);

    // R11 hold without strobe
    @(negedge clk);
    op_class = 4'd1; opa = 32'h0; opb = 32'h9; prev_flags = 4'hf; x_in = ~m_x;
    repeat (3) @(negedge clk);
    cmp("R11 hold flags", {60'd0, flags_q}, {60'd0, m_flags});
    cmp("R11 hold result", {32'd0, result_q}, {32'd0, m_res});
    cmp("R11 hold extend", {63'd0, x_q}, {63'd0, m_x});
    cmp("R11 done low when idle", {63'd0, done_q}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule